// File: doc/BRIEF.md
# 8-bit Compare-and-Clear Timer with Interrupt Flags

This block is an 8-bit up-counter that a CPU reaches over a byte-wide register bus. A count-enable input advances it by one per enabled cycle. A compare register is checked against the counter on every counting step. When the counter steps onto the compare value, a compare flag is set. With the clear mode bit set, the next enabled step returns the counter to zero instead of going on, so the counter repeats with a period of compare value plus one. A separate overflow flag is set when a plain increment carries the counter from its top value back to zero.

Software can load both the counter and the compare register. Neither load can produce a match or an overflow. Only counting does. Each flag has a mask bit. An interrupt request line is a level signal: it is high while its flag, its mask bit and a global interrupt-enable input are all set. Flags are cleared by writing a one to them.

Top module: `tmr8_cmpclr`

## Requirements
- R1: After reset the counter reads 0x00, the compare register reads 0xFF, and the mask, flag and control registers read 0x00.
- R2: Register addresses are: compare 0x2D, flag 0x38, mask 0x39, counter 0x2F, control 0x30. Mask bit 7 always reads 0. Only flag bits 6 (compare) and 2 (overflow) can read 1. Only control bit 0 (clear mode) is stored.
- R3: In each cycle with count enable high and no counter write, the counter moves one step. Without enable or write it holds.
- R4: A counter write in the same cycle as count enable loads the written value, not the increment. No compare or overflow event is raised in that cycle.
- R5: Flag bit 6 is set at the clock edge where a counting step makes the counter equal to the compare value.
- R6: A software write that makes the counter and the compare register equal, whichever of the two is written, does not set flag bit 6.
- R7: With control bit 0 set, the enabled step after a compare match loads zero. With it clear, the counter continues to compare value plus one.
- R8: Flag bit 2 is set when an increment takes the counter from 0xFF to 0x00. A return to zero caused by clear mode does not set it.
- R9: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R10: Output irq_cmp is high exactly while flag bit 6, mask bit 6 and input gie are all 1. It stays high until one of them is cleared.
- R11: Output irq_ovf is high exactly while flag bit 2, mask bit 2 and input gie are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_en | input | 1 | Advance the counter this cycle |
| gie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq_cmp | output | 1 | Compare interrupt request, level |
| irq_ovf | output | 1 | Overflow interrupt request, level |

## Verification
The bench targets the loads that land on the compare value: writing the counter, or the compare register, to the current count. A design that compares levels instead of counting steps would raise a false compare flag on these loads. It drives clear mode with a compare value of 0xFF, where a design that treats every return to zero as an overflow would set flag bit 2. It also drives a hardware set and a software clear of the same flag in one cycle, and a counter load during count enable. A wrong priority in either case would lose the flag, or would let the increment win over the loaded value. Interrupt lines are held over many cycles and gated in turn by mask and gie, which exposes pulse-style or ungated requests.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam logic [AW-1:0] A_CMP = 8'h2D;
  localparam logic [AW-1:0] A_FLG = 8'h38;
  localparam logic [AW-1:0] A_MSK = 8'h39;
  localparam logic [AW-1:0] A_CNT = 8'h2F;
  localparam logic [AW-1:0] A_CTL = 8'h30;
  localparam int BIT_CMP = 6;
  localparam int BIT_OVF = 2;
  localparam int BIT_CLR = 0;
endpackage

// File: rtl/tmr8_core.sv
module tmr8_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         clr_mode,
  input  logic         cnt_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] cmp_val,
  output logic [W-1:0] cnt,
  output logic         match_evt,
  output logic         ovf_evt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, step_val;
  logic         at_match_q, at_match_d;
  logic         step, clear_now;

  always_comb begin
    step      = cnt_en && !cnt_wr;
    clear_now = clr_mode && at_match_q;
    step_val  = clear_now ? '0 : cnt_q + 1'b1;
    match_evt = step && (step_val == cmp_val);
    ovf_evt   = step && !clear_now && (cnt_q == TOP);
    cnt_d      = cnt_q;
    at_match_d = at_match_q;
    if (cnt_wr) begin
      cnt_d      = wdata;
      at_match_d = 1'b0;
    end else if (step) begin
      cnt_d      = step_val;
      at_match_d = match_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      at_match_q <= 1'b0;
    end else begin
      cnt_q      <= cnt_d;
      at_match_q <= at_match_d;
    end
  end

  assign cnt = cnt_q;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_wr) |=> $stable(cnt_q));
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata)));
  a_r6_no_match_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |-> (!match_evt && !ovf_evt));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && at_match_q && cnt_en && !cnt_wr) |=> (cnt_q == '0));
  a_r8_clear_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode && at_match_q) |-> !ovf_evt);
endmodule

// File: rtl/tmr8_irq.sv
module tmr8_irq
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         match_evt,
  input  logic         ovf_evt,
  input  logic         msk_wr,
  input  logic         flg_wr,
  input  logic [W-1:0] wdata,
  input  logic         gie,
  output logic [W-1:0] msk_rd,
  output logic [W-1:0] flg_rd,
  output logic         irq_cmp,
  output logic         irq_ovf
);
  logic [W-2:0] msk_q, msk_d;
  logic         fc_q, fc_d, fo_q, fo_d;
  logic         clr_c, clr_o;

  always_comb begin
    msk_d = msk_wr ? wdata[W-2:0] : msk_q;
    clr_c = flg_wr && wdata[BIT_CMP];
    clr_o = flg_wr && wdata[BIT_OVF];
    fc_d  = match_evt ? 1'b1 : (clr_c ? 1'b0 : fc_q);
    fo_d  = ovf_evt   ? 1'b1 : (clr_o ? 1'b0 : fo_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_q <= '0;
      fc_q  <= 1'b0;
      fo_q  <= 1'b0;
    end else begin
      msk_q <= msk_d;
      fc_q  <= fc_d;
      fo_q  <= fo_d;
    end
  end

  always_comb begin
    msk_rd = {1'b0, msk_q};
    flg_rd = '0;
    flg_rd[BIT_CMP] = fc_q;
    flg_rd[BIT_OVF] = fo_q;
  end

  assign irq_cmp = gie && msk_q[BIT_CMP] && fc_q;
  assign irq_ovf = gie && msk_q[BIT_OVF] && fo_q;

  a_r9_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> fc_q);
  a_r9_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_c && !match_evt) |=> !fc_q);
  a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_o && !ovf_evt) |=> (fo_q == $past(fo_q)));
  a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cmp && gie && !clr_c && !msk_wr) |=> irq_cmp || !gie);
endmodule

// File: rtl/tmr8_regs.sv
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  input  logic [W-1:0]  cnt,
  input  logic [W-1:0]  msk_rd,
  input  logic [W-1:0]  flg_rd,
  output logic          cnt_wr,
  output logic          msk_wr,
  output logic          flg_wr,
  output logic [W-1:0]  cmp_val,
  output logic          clr_mode,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cmp_q, cmp_d;
  logic         ctl_q, ctl_d;
  logic         cmp_wr, ctl_wr;

  always_comb begin
    cnt_wr = bus_we && (bus_addr == A_CNT);
    cmp_wr = bus_we && (bus_addr == A_CMP);
    msk_wr = bus_we && (bus_addr == A_MSK);
    flg_wr = bus_we && (bus_addr == A_FLG);
    ctl_wr = bus_we && (bus_addr == A_CTL);
    cmp_d  = cmp_wr ? bus_wdata : cmp_q;
    ctl_d  = ctl_wr ? bus_wdata[BIT_CLR] : ctl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      ctl_q <= 1'b0;
    end else begin
      cmp_q <= cmp_d;
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (bus_addr)
      A_CMP:   rdata = cmp_q;
      A_CNT:   rdata = cnt;
      A_MSK:   rdata = msk_rd;
      A_FLG:   rdata = flg_rd;
      A_CTL:   rdata[BIT_CLR] = ctl_q;
      default: rdata = '0;
    endcase
  end

  assign cmp_val  = cmp_q;
  assign clr_mode = ctl_q;

  a_r2_flag_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_FLG) |-> (rdata[W-1] == 1'b0 && rdata[0] == 1'b0));
  a_r2_mask_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MSK) |-> (rdata[W-1] == 1'b0));
  a_r6_cmp_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> (cmp_q == $past(bus_wdata)));
endmodule

// File: rtl/tmr8_cmpclr.sv
module tmr8_cmpclr
  import tmr8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          gie,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_cmp,
  output logic          irq_ovf
);
  logic [DW-1:0] cnt, cmp_val, msk_rd, flg_rd;
  logic          cnt_wr, msk_wr, flg_wr, clr_mode, match_evt, ovf_evt;

  tmr8_regs #(.W(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt), .msk_rd(msk_rd), .flg_rd(flg_rd),
    .cnt_wr(cnt_wr), .msk_wr(msk_wr), .flg_wr(flg_wr), .cmp_val(cmp_val),
    .clr_mode(clr_mode), .rdata(bus_rdata)
  );

  tmr8_core #(.W(DW)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr_mode(clr_mode),
    .cnt_wr(cnt_wr), .wdata(bus_wdata), .cmp_val(cmp_val), .cnt(cnt),
    .match_evt(match_evt), .ovf_evt(ovf_evt)
  );

  tmr8_irq #(.W(DW)) u_irq (
    .clk(clk), .rst_n(rst_n), .match_evt(match_evt), .ovf_evt(ovf_evt),
    .msk_wr(msk_wr), .flg_wr(flg_wr), .wdata(bus_wdata), .gie(gie),
    .msk_rd(msk_rd), .flg_rd(flg_rd), .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  a_r10_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!irq_cmp && !irq_ovf));
  a_r11_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !msk_rd[BIT_OVF] |-> !irq_ovf);
endmodule

// File: tb/sim_tmr8_cmpclr.sv
module sim_tmr8_cmpclr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       gie = 1'b0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_cmp, irq_ovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] CMP = 8'h2D, FLG = 8'h38, MSK = 8'h39,
                         CNT = 8'h2F, CTL = 8'h30;
  localparam logic [1:0] WR = 2'd0, RD = 2'd1, CT = 2'd2;

  always #10 clk = ~clk;

  tmr8_cmpclr u0 (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gie(gie), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
  );

  function automatic logic [31:0] mk(input logic [3:0] rq, input logic [1:0] op,
                                     input logic [7:0] a, input logic [7:0] d,
                                     input logic [7:0] e);
    return {rq, 2'b00, op, a, d, e};
  endfunction

  // fields: requirement number, operation, address, data or count, expected read
  localparam int NV = 62;
  localparam logic [31:0] VEC [0:NV-1] = '{
    mk(1, RD, CMP, 0, 8'hFF), mk(1, RD, MSK, 0, 0), mk(1, RD, FLG, 0, 0),        // R1
    mk(1, RD, CNT, 0, 0),     mk(1, RD, CTL, 0, 0),
    mk(0, WR, CMP, 8'h05, 0), mk(0, CT, 0, 3, 0),  mk(3, RD, CNT, 0, 8'h03),   // R3
    mk(5, RD, FLG, 0, 0),     mk(0, CT, 0, 2, 0),  mk(5, RD, FLG, 0, 8'h40),   // R5
    mk(3, RD, CNT, 0, 8'h05),
    mk(0, WR, FLG, 8'h00, 0), mk(9, RD, FLG, 0, 8'h40),                          // R9
    mk(0, WR, FLG, 8'hBF, 0), mk(9, RD, FLG, 0, 8'h40),
    mk(0, WR, FLG, 8'h40, 0), mk(9, RD, FLG, 0, 8'h00),
    mk(0, WR, CNT, 8'h05, 0), mk(6, RD, FLG, 0, 0),                              // R6
    mk(0, WR, CNT, 8'h03, 0), mk(0, WR, CMP, 8'h03, 0), mk(6, RD, FLG, 0, 0),
    mk(0, CT, 0, 1, 0),       mk(3, RD, CNT, 0, 8'h04),
    mk(0, WR, CMP, 8'h10, 0), mk(0, WR, CTL, 8'h01, 0), mk(0, CT, 0, 12, 0),    // R7
    mk(5, RD, FLG, 0, 8'h40), mk(7, RD, CNT, 0, 8'h10),
    mk(0, CT, 0, 1, 0),       mk(7, RD, CNT, 0, 8'h00), mk(8, RD, FLG, 0, 8'h40),
    mk(0, WR, FLG, 8'h44, 0), mk(0, WR, CTL, 8'h00, 0), mk(0, WR, CMP, 8'h80, 0), // R8
    mk(0, WR, CNT, 8'hFE, 0), mk(0, CT, 0, 2, 0),  mk(8, RD, FLG, 0, 8'h04),
    mk(3, RD, CNT, 0, 8'h00),
    mk(0, WR, FLG, 8'h44, 0), mk(0, WR, CTL, 8'h01, 0), mk(0, WR, CMP, 8'hFF, 0),
    mk(0, WR, CNT, 8'hFD, 0), mk(0, CT, 0, 2, 0),  mk(5, RD, FLG, 0, 8'h40),
    mk(0, CT, 0, 1, 0),       mk(8, RD, FLG, 0, 8'h40), mk(7, RD, CNT, 0, 8'h00),
    mk(0, WR, CTL, 8'h00, 0), mk(0, WR, CMP, 8'h03, 0), mk(0, WR, CNT, 8'h01, 0),
    mk(0, CT, 0, 3, 0),       mk(7, RD, CNT, 0, 8'h04),
    mk(0, WR, MSK, 8'hFF, 0), mk(2, RD, MSK, 0, 8'h7F),                          // R2
    mk(0, WR, FLG, 8'hFF, 0), mk(2, RD, FLG, 0, 8'h00),
    mk(0, WR, CTL, 8'hFF, 0), mk(2, RD, CTL, 0, 8'h01),
    mk(0, WR, CTL, 8'h00, 0), mk(0, WR, MSK, 8'h00, 0)
  };

  task automatic check(input int rq, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d got %02h expected %02h at %0t", rq, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int rq, input logic [7:0] a, input logic [7:0] e);
    bus_addr = a;
    #2;
    check(rq, bus_rdata, e);
  endtask

  task automatic count(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][25:24])
        WR: wr(VEC[i][23:16], VEC[i][15:8]);
        RD: rd(int'(VEC[i][31:28]), VEC[i][23:16], VEC[i][7:0]);
        default: count(int'(VEC[i][15:8]));
      endcase
    end

    // R10: compare request gated by mask and gie, level while held
    wr(CMP, 8'h20); wr(CNT, 8'h1F); count(1);
    #2 check(10, {7'd0, irq_cmp}, 8'd0);
    wr(MSK, 8'h40);
    #2 check(10, {7'd0, irq_cmp}, 8'd0);
    gie = 1'b1;
    #2 check(10, {7'd0, irq_cmp}, 8'd1);
    repeat (6) @(negedge clk);
    #2 check(10, {7'd0, irq_cmp}, 8'd1);
    wr(MSK, 8'h00);
    #2 check(10, {7'd0, irq_cmp}, 8'd0);
    wr(MSK, 8'h40);
    #2 check(10, {7'd0, irq_cmp}, 8'd1);
    wr(FLG, 8'h40);
    #2 check(10, {7'd0, irq_cmp}, 8'd0);

    // R11: overflow request
    wr(MSK, 8'h04); wr(CNT, 8'hFF); count(1);
    #2 check(11, {7'd0, irq_ovf}, 8'd1);
    check(11, {7'd0, irq_cmp}, 8'd0);
    gie = 1'b0;
    #2 check(11, {7'd0, irq_ovf}, 8'd0);
    gie = 1'b1;
    wr(FLG, 8'h04);
    #2 check(11, {7'd0, irq_ovf}, 8'd0);
    gie = 1'b0;

    // R9: hardware set and software clear in the same cycle
    wr(CNT, 8'h1F);
    cnt_en = 1'b1;
    wr(FLG, 8'h40);
    cnt_en = 1'b0;
    rd(9, FLG, 8'h40);
    rd(5, CNT, 8'h20);

    // R4: counter load during count enable wins and raises no match
    wr(FLG, 8'h44); wr(CNT, 8'h10);
    cnt_en = 1'b1;
    wr(CNT, 8'h20);
    cnt_en = 1'b0;
    rd(4, CNT, 8'h20);
    rd(4, FLG, 8'h00);
    cnt_en = 1'b1;
    wr(CNT, 8'h55);
    cnt_en = 1'b0;
    rd(4, CNT, 8'h55);

    // R1: reset in mid run
    wr(CMP, 8'h33); count(3);
    do_reset();
    rd(1, CNT, 8'h00);
    rd(1, CMP, 8'hFF);
    rd(1, FLG, 8'h00);
    rd(1, MSK, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule